// File: doc/BRIEF.md
# Slow Peripheral Enable Clock and Address-Valid Pacer

This block derives a slow, free-running enable clock from the main clock. Older synchronous peripherals use it as their only timing reference. The enable clock, `pe_clk`, has a ten-clock period. Each period starts with six clocks low and ends with four clocks high. It runs all the time, whatever the bus is doing, and it comes from a one-hot ring of flops.

The block also paces a bus cycle onto that enable clock.

- **Recognition.** While the bus master sits in its S4 wait state with address strobe low, it can see the peripheral-select input asserted. The block then takes that cycle over as a peripheral cycle.
- **Address valid.** At the next start of an enable-low phase, the block asserts the active-low address-valid output.
- **Completion.** On the last clock of the following enable-high phase, the block raises a single-cycle completion pulse. This pulse lets the bus master close the cycle.
- **Release.** Address-valid is released as soon as address strobe is negated.

Data latching and the master's own bus state sequence are handled elsewhere. All pins are plain control pins. There is no data stream and no back-pressure.

Top module: `slow_periph_pacer`

## Requirements
- R1: While `rst` is high and in the first clock after it is released, `pe_clk` is 0, `paddr_ok_n` is 1 and `pcyc_done` is 0. The first period after reset begins with its low phase.
- R2: `pe_clk` repeats a ten-clock period, six clocks at 0 followed by four clocks at 1. The bus inputs have no effect on it.
- R3: A peripheral cycle is recognized only at a clock edge that samples `bus_s4`=1, `as_n`=0 and `psel_n`=0 together. A low `psel_n` without `bus_s4`, or with `as_n` high, produces no address-valid.
- R4: After recognition, `paddr_ok_n` goes low at the first falling edge of `pe_clk` that comes strictly later than the recognition edge. It goes low at that same edge.
- R5: `pcyc_done` is high for exactly one clock: the last clock of the high phase that follows the assertion of `paddr_ok_n`. This is the ninth clock after `paddr_ok_n` fell, and `pe_clk` falls at the next edge.
- R6: After the completion pulse, `paddr_ok_n` stays low until `as_n` goes high. It is 1 in every clock in which `as_n` is 1.
- R7: If `as_n` goes high after recognition but before address-valid asserts, the cycle is abandoned. No address-valid and no completion pulse are produced.
- R8: Ordinary cycles, where `psel_n` stays high through S4, never assert `paddr_ok_n` or `pcyc_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_s4 | input | 1 | High while the bus master is in its S4 state |
| psel_n | input | 1 | Peripheral-select from address decode, active low |
| as_n | input | 1 | Address strobe, active low |
| pe_clk | output | 1 | Slow enable clock, 6 low / 4 high |
| paddr_ok_n | output | 1 | Address valid for slow peripherals, active low |
| pcyc_done | output | 1 | One-clock completion pulse for the bus cycle |

## Verification
The assertions rely on a few properties of the inputs:

- `as_n` changes only between clock edges and does not pulse high and back low within one clock.
- `bus_s4` is raised only while `as_n` is low.
- `as_n` is held low at least one clock past the completion pulse when a peripheral cycle is meant to finish normally.

The stimulus drives every input at the falling clock edge and keeps `as_n` low for one to several clocks after the pulse. It starts peripheral cycles at all ten phases of `pe_clk`. It also covers aborted cycles, select without S4, and select with strobe high.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    HS_IDLE   = 2'd0,
    HS_WAIT   = 2'd1,
    HS_ACTIVE = 2'd2,
    HS_HOLD   = 2'd3
  } hs_state_e;

endpackage

// File: rtl/psc_ring.sv
module psc_ring #(
  parameter int LOW_CLKS  = 6,
  parameter int HIGH_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  output logic e_o,
  output logic last_high_o
);
  localparam int PERIOD = LOW_CLKS + HIGH_CLKS;
  localparam int CW     = $clog2(PERIOD + 1);

  logic [PERIOD-1:0]    ring_q;
  logic [PERIOD-1:0]    ring_d;
  logic [HIGH_CLKS-1:0] high_taps;
  logic                 legal;

  // Any pattern that is not exactly one-hot is replaced by the phase-0 pattern.
  always_comb begin
    legal  = $onehot(ring_q);
    ring_d = legal ? {ring_q[PERIOD-2:0], ring_q[PERIOD-1]} : PERIOD'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) ring_q <= PERIOD'(1);
    else     ring_q <= ring_d;
  end

  for (genvar i = 0; i < HIGH_CLKS; i++) begin : g_high
    assign high_taps[i] = ring_q[LOW_CLKS + i];
  end

  assign e_o         = |high_taps;
  assign last_high_o = ring_q[PERIOD-1];

  // Run-length tracker for the duty-cycle checks.
  logic          e_last_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_last_q <= 1'b0;
      run_q    <= '0;
    end else begin
      e_last_q <= e_o;
      run_q    <= (e_o != e_last_q) ? CW'(1) : run_q + CW'(1);
    end
  end

  AST_E_LOW_RUN:  assert property (@(posedge clk) disable iff (rst)
                    (e_o && !e_last_q) |-> (run_q == CW'(LOW_CLKS)));   // R2
  AST_E_HIGH_RUN: assert property (@(posedge clk) disable iff (rst)
                    (!e_o && e_last_q) |-> (run_q == CW'(HIGH_CLKS)));  // R2
endmodule

// File: rtl/psc_handshake.sv
module psc_handshake
  import psc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic s4_i,
  input  logic psel_n_i,
  input  logic as_n_i,
  input  logic last_high_i,
  output logic vma_o,
  output logic term_o
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE:   if (s4_i && !psel_n_i && !as_n_i) state_d = HS_WAIT;
      HS_WAIT:   if (as_n_i) state_d = HS_IDLE;
                 else if (last_high_i) state_d = HS_ACTIVE;
      HS_ACTIVE: if (as_n_i) state_d = HS_IDLE;
                 else if (last_high_i) state_d = HS_HOLD;
      HS_HOLD:   if (as_n_i) state_d = HS_IDLE;
      default:   state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= HS_IDLE;
    else     state_q <= state_d;
  end

  assign vma_o  = (state_q == HS_ACTIVE) || (state_q == HS_HOLD);
  assign term_o = (state_q == HS_ACTIVE) && last_high_i && !as_n_i;

  AST_TERM_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
                        term_o |=> !term_o);                               // R5
  AST_HOLD_AFTER_TERM: assert property (@(posedge clk) disable iff (rst)
                        (term_o && !as_n_i) |=> vma_o);                    // R6
endmodule

// File: rtl/slow_periph_pacer.sv
module slow_periph_pacer #(
  parameter int LOW_CLKS  = 6,
  parameter int HIGH_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_s4,
  input  logic psel_n,
  input  logic as_n,
  output logic pe_clk,
  output logic paddr_ok_n,
  output logic pcyc_done
);
  logic last_high;
  logic vma_held;

  psc_ring #(
    .LOW_CLKS (LOW_CLKS),
    .HIGH_CLKS(HIGH_CLKS)
  ) u_ring (
    .clk        (clk),
    .rst        (rst),
    .e_o        (pe_clk),
    .last_high_o(last_high)
  );

  psc_handshake u_hs (
    .clk        (clk),
    .rst        (rst),
    .s4_i       (bus_s4),
    .psel_n_i   (psel_n),
    .as_n_i     (as_n),
    .last_high_i(last_high),
    .vma_o      (vma_held),
    .term_o     (pcyc_done)
  );

  // Address-valid drops at once when the strobe is negated.
  assign paddr_ok_n = ~(vma_held & ~as_n);

  AST_VMA_ON_E_FALL:  assert property (@(posedge clk) disable iff (rst)
                        $fell(paddr_ok_n) |-> $fell(pe_clk));              // R4
  AST_DONE_E_HIGH:    assert property (@(posedge clk) disable iff (rst)
                        pcyc_done |-> (pe_clk && !paddr_ok_n));            // R5
  AST_DONE_THEN_FALL: assert property (@(posedge clk) disable iff (rst)
                        pcyc_done |=> !pe_clk);                            // R5
  AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
                        as_n |-> paddr_ok_n);                              // R6
endmodule

// File: tb/test_slow_periph_pacer.sv
module test_slow_periph_pacer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_s4 = 1'b0;
  logic psel_n = 1'b1;
  logic as_n = 1'b1;
  logic pe_clk, paddr_ok_n, pcyc_done;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;
  string req_tag = "R8";

  typedef struct { int v_start; int t_done; } exp_item_t;
  exp_item_t sb_q[$];

  always #5 clk = ~clk;

  slow_periph_pacer i_slow_periph_pacer (
    .clk(clk), .rst(rst), .bus_s4(bus_s4), .psel_n(psel_n), .as_n(as_n),
    .pe_clk(pe_clk), .paddr_ok_n(paddr_ok_n), .pcyc_done(pcyc_done)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check_bit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  // Monitor: compares every cycle against the model and the scoreboard.
  initial begin
    logic exp_e, exp_vma_n, exp_done;
    @(negedge rst);
    forever begin
      @(negedge clk); #1;
      if (done) break;
      exp_e = ((cyc % 10) >= 6);
      check_bit((cyc < 10) ? "R1" : "R2", "pe_clk", pe_clk, exp_e);
      exp_vma_n = 1'b1;
      exp_done  = 1'b0;
      if (sb_q.size() > 0) begin
        if (cyc >= sb_q[0].v_start && !as_n) exp_vma_n = 1'b0;
        if (cyc == sb_q[0].t_done) exp_done = 1'b1;
      end
      check_bit((sb_q.size() > 0) ? ((cyc > sb_q[0].t_done) ? "R6" : "R4") : req_tag,
                "paddr_ok_n", paddr_ok_n, exp_vma_n);
      check_bit((sb_q.size() > 0) ? "R5" : req_tag, "pcyc_done", pcyc_done, exp_done);
      if (sb_q.size() > 0 && as_n && cyc > sb_q[0].t_done) void'(sb_q.pop_front());
    end
  end

  task automatic wait_phase(int p);
    do @(negedge clk); while ((cyc % 10) != p);
  endtask

  // Driver: one peripheral cycle started at E phase p, strobe held `hold` clocks past the pulse.
  task automatic periph_cycle(int p, int hold);
    exp_item_t it;
    int c;
    wait_phase(p);
    c = cyc;
    it.v_start = ((c + 2 + 9) / 10) * 10;
    it.t_done  = it.v_start + 9;
    sb_q.push_back(it);
    as_n = 1'b0; bus_s4 = 1'b1; psel_n = 1'b0;
    @(negedge clk);
    bus_s4 = 1'b0;
    while (cyc < it.t_done + hold) @(negedge clk);
    as_n = 1'b1; psel_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check_bit("R1", "pe_clk in reset", pe_clk, 1'b0);
    check_bit("R1", "paddr_ok_n in reset", paddr_ok_n, 1'b1);
    check_bit("R1", "pcyc_done in reset", pcyc_done, 1'b0);
    rst = 1'b0;
    repeat (25) @(negedge clk);

    // R8: ordinary cycle, select stays high through S4
    req_tag = "R8";
    as_n = 1'b0; bus_s4 = 1'b1;
    @(negedge clk); bus_s4 = 1'b0;
    repeat (15) @(negedge clk); as_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: select without S4, then select and S4 with strobe high
    req_tag = "R3";
    as_n = 1'b0; psel_n = 1'b0;
    repeat (15) @(negedge clk);
    as_n = 1'b1; bus_s4 = 1'b1;
    repeat (12) @(negedge clk);
    bus_s4 = 1'b0; psel_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 R5 R6: start at every phase of pe_clk, varied strobe hold
    req_tag = "R4";
    for (int p = 0; p < 10; p++) periph_cycle(p, 1 + (p % 4));

    // R7: abandon before address-valid asserts
    req_tag = "R7";
    wait_phase(0);
    as_n = 1'b0; bus_s4 = 1'b1; psel_n = 1'b0;
    @(negedge clk); bus_s4 = 1'b0;
    repeat (3) @(negedge clk);
    as_n = 1'b1; psel_n = 1'b1;
    repeat (20) @(negedge clk);

    // R6: long hold after completion, then back-to-back cycle
    req_tag = "R6";
    periph_cycle(3, 7);
    periph_cycle(8, 1);
    repeat (30) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule